// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter

This block turns a stream of bytes into bit-stuffed, flag-delimited frames on one serial transmit line. A producer hands bytes over through a one-entry holding register with a valid/ready handshake; a marker that travels with a byte says that it is the last byte of the frame. Each bit leaves on a cycle in which the one-cycle transmit-clock enable `bit_en` is high. All other cycles only move the handshake.

On its own, the block sends the opening flag (0x7E). It presets the check sequence generator and stuffs a zero after every five ones inside the frame. It appends the inverted 16-bit check sequence and closes with a flag. If the next frame's first byte is already held when a closing flag ends, that flag also opens the next frame. The block can abort a frame on request. It codes the line as NRZ or NRZI. It raises a request-to-send output for the length of the transmission and clears it again by itself.

Top module: `bitframe_tx`

## Requirements
- R1: `in_ready` is high exactly when the holding register is empty. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high, and the held value stays unchanged until the serializer takes it.
- R2: When `tx_enable` is high and a byte is held, a flag 01111110 is sent before that byte without any command. While `tx_enable` is low, no frame starts.
- R3: Data bits are sent least significant bit first.
- R4: Inside the data and check-sequence fields, a 0 is inserted after every five consecutive 1 bits. Flag and abort patterns are sent without insertion.
- R5: At the start of each frame, the 16-bit check register is preset to all ones when `cfg_crc_ones` is 1, and to all zeros when it is 0.
- R6: The check sequence uses polynomial x^16+x^12+x^5+1. Each data bit is fed in order of transmission into a shift-left register, where feedback = reg[15] xor bit. The register is sent inverted: bits 15..8 first, then bits 7..0, each byte least significant bit first. A closing flag follows.
- R7: A frame ends with the check sequence and a closing flag after the byte marked by `in_eom`. It also ends this way when the holding register is empty at a byte boundary inside the frame (underrun).
- R8: If the next byte is held when a closing flag ends, the next frame starts right after that flag, which serves as its opening flag.
- R9: When `abort_req` is pulsed during the data or check field, the frame ends at the next bit time with eight consecutive 1s and no insertion. The held byte is dropped, and the block returns to idle.
- R10: With `cfg_nrzi` = 0 the line carries the bits directly. With `cfg_nrzi` = 1 a 0 toggles the line and a 1 holds it, and the line is forced high once the closing flag or abort ends.
- R11: `rts` rises when a frame is about to start. It falls one bit time after the closing flag of the last frame, or after an abort.
- R12: `eom_flag` is set when the check sequence of a frame begins, whether by end marker or by underrun. It clears by itself when the next frame's first byte is loaded.
- R13: While idle, the line sends marks (1s). With `cfg_idle_flags` = 1 and `cfg_nrzi` = 0 it sends flags instead, and `rts` stays low.
- R14: After reset: `txd` = 1, `rts` = 0, `in_ready` = 1, `eom_flag` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle transmit bit enable |
| tx_enable | input | 1 | Allows new frames to start |
| cfg_nrzi | input | 1 | 1 = NRZI line coding, 0 = NRZ |
| cfg_crc_ones | input | 1 | 1 = preset check register to ones, 0 = zeros |
| cfg_idle_flags | input | 1 | 1 = send flags while idle (NRZ only) |
| abort_req | input | 1 | Pulse to abort the current frame |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_eom | input | 1 | Offered byte is the last of its frame |
| in_ready | output | 1 | Holding register empty |
| txd | output | 1 | Serial line |
| rts | output | 1 | Request to send |
| eom_flag | output | 1 | End-of-message / underrun latch |

## Verification
The hardest case to reach is the shared flag between frames. It needs the next frame's first byte to wait in the holding register through the whole check sequence and closing flag of the previous frame. The bench gets there by calling the frame driver twice in a row: the first byte of the second frame blocks in the handshake until the last byte of the first frame is loaded, and then sits in the register. A bench deframer decodes the line, removes stuffed zeros and counts flags. The flag count between the two frames shows whether the flag was shared. The same deframer detects aborts from runs of seven ones. The abort is pulsed right after the second byte of a frame has been accepted, so it lands in the data field.

// File: rtl/bitframe_pkg.sv
package bitframe_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned CRC_W     = 16;
    localparam int unsigned STUFF_RUN = 5;
    localparam logic [DATA_W-1:0] FLAG_PAT = 8'h7E;
    localparam logic [CRC_W-1:0]  CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FLAG,
        ST_DATA,
        ST_FCS,
        ST_ABORT
    } tx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              eom;
    } hold_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = c[CRC_W-1] ^ b;
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/bf_hold.sv
module bf_hold
    import bitframe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              take,
    input  logic              flush,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eom,
    output logic              in_ready,
    output logic              full,
    output hold_t             held
);

    assign in_ready = !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (in_valid && !full) begin
            full <= 1'b1;
            held <= '{data: in_data, eom: in_eom};
        end else if (take || flush) begin
            full <= 1'b0;
        end
    end

    // R1: a held byte stays put until it is taken or flushed
    assert_hold_keep_R1: assert property (@(posedge clk) disable iff (rst)
        (full && !take && !flush) |=> (full && $stable(held)));

endmodule

// File: rtl/bf_crc.sv
module bf_crc
    import bitframe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             preset,
    input  logic             preset_ones,
    input  logic             step,
    input  logic             din,
    output logic [CRC_W-1:0] crc
);

    always_ff @(posedge clk) begin
        if (rst)         crc <= '1;
        else if (preset) crc <= preset_ones ? '1 : '0;
        else if (step)   crc <= crc_step(crc, din);
    end

endmodule

// File: rtl/bf_line.sv
module bf_line (
    input  logic clk,
    input  logic rst,
    input  logic bit_en,
    input  logic nrzi,
    input  logic force_high,
    input  logic bit_in,
    output logic line
);

    always_ff @(posedge clk) begin
        if (rst) begin
            line <= 1'b1;
        end else if (bit_en) begin
            if (force_high) line <= 1'b1;
            else if (nrzi)  line <= bit_in ? line : ~line;
            else            line <= bit_in;
        end
    end

endmodule

// File: rtl/bitframe_tx.sv
module bitframe_tx
    import bitframe_pkg::*;
#(
    parameter int unsigned ABORT_ONES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              tx_enable,
    input  logic              cfg_nrzi,
    input  logic              cfg_crc_ones,
    input  logic              cfg_idle_flags,
    input  logic              abort_req,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eom,
    output logic              in_ready,
    output logic              txd,
    output logic              rts,
    output logic              eom_flag
);

    localparam int unsigned CW = $clog2(DATA_W);
    localparam int unsigned AW = $clog2(ABORT_ONES);
    localparam int unsigned OW = $clog2(STUFF_RUN + 1);
    localparam logic [CW-1:0] LAST_BIT  = CW'(DATA_W - 1);
    localparam logic [AW-1:0] ABORT_END = AW'(ABORT_ONES - 2);

    tx_state_e         st;
    logic [CW-1:0]     cnt;
    logic [AW-1:0]     acnt;
    logic [DATA_W-1:0] sh;
    logic              cur_eom;
    logic              fcs_lo;
    logic [OW-1:0]     ones;
    logic              abort_pend;

    logic              hold_full;
    hold_t             held;
    logic [CRC_W-1:0]  crc;

    logic              abort_go, stuff, field_bit, tx_bit;
    logic              flag_end, start_frame, mid_load, take, crc_en, byte_end;

    assign abort_go  = bit_en && (abort_pend || abort_req) && (st == ST_DATA || st == ST_FCS);
    assign stuff     = (ones == OW'(STUFF_RUN)) && (st == ST_DATA || st == ST_FCS || st == ST_FLAG);
    assign field_bit = (st == ST_FCS) ? ~crc[{~fcs_lo, cnt}] : sh[0];
    assign byte_end  = !stuff && (cnt == LAST_BIT);

    always_comb begin
        tx_bit = 1'b1;
        if (!abort_go) begin
            case (st)
                ST_FLAG:          tx_bit = stuff ? 1'b0 : FLAG_PAT[cnt];
                ST_DATA, ST_FCS:  tx_bit = stuff ? 1'b0 : field_bit;
                default:          tx_bit = 1'b1;
            endcase
        end
    end

    assign flag_end    = (st == ST_FLAG) && byte_end;
    assign start_frame = flag_end && tx_enable && hold_full && rts;
    assign mid_load    = (st == ST_DATA) && byte_end && !cur_eom && hold_full;
    assign take        = bit_en && !abort_go && (start_frame || mid_load);
    assign crc_en      = bit_en && !abort_go && (st == ST_DATA) && !stuff;

    bf_hold u_hold (
        .clk(clk), .rst(rst), .take(take), .flush(abort_go),
        .in_valid(in_valid), .in_data(in_data), .in_eom(in_eom),
        .in_ready(in_ready), .full(hold_full), .held(held)
    );

    bf_crc u_crc (
        .clk(clk), .rst(rst), .preset(bit_en && start_frame), .preset_ones(cfg_crc_ones),
        .step(crc_en), .din(sh[0]), .crc(crc)
    );

    bf_line u_line (
        .clk(clk), .rst(rst), .bit_en(bit_en), .nrzi(cfg_nrzi),
        .force_high(st == ST_IDLE && cfg_nrzi), .bit_in(tx_bit), .line(txd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE; cnt <= '0; acnt <= '0; sh <= '0; cur_eom <= 1'b0;
            fcs_lo <= 1'b0; ones <= '0; rts <= 1'b0; eom_flag <= 1'b0; abort_pend <= 1'b0;
        end else begin
            if (abort_req) abort_pend <= 1'b1;
            if (abort_go) begin
                st <= ST_ABORT; acnt <= '0; ones <= '0; abort_pend <= 1'b0;
            end else if (bit_en) begin
                case (st)
                    ST_IDLE: begin
                        abort_pend <= 1'b0;
                        cnt <= '0;
                        if (tx_enable && hold_full) begin
                            st <= ST_FLAG; rts <= 1'b1;
                        end else begin
                            rts <= 1'b0;
                            if (cfg_idle_flags && !cfg_nrzi) st <= ST_FLAG;
                        end
                    end
                    ST_FLAG: begin
                        ones <= '0;
                        if (!stuff) begin
                            cnt <= cnt + 1'b1;
                            if (flag_end) begin
                                if (start_frame) begin
                                    st <= ST_DATA; sh <= held.data; cur_eom <= held.eom;
                                    eom_flag <= 1'b0;
                                end else if (tx_enable && hold_full) begin
                                    rts <= 1'b1;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end
                        end
                    end
                    ST_DATA, ST_FCS: begin
                        if (stuff) begin
                            ones <= '0;
                        end else begin
                            ones <= tx_bit ? ones + 1'b1 : '0;
                            sh   <= sh >> 1;
                            cnt  <= cnt + 1'b1;
                            if (byte_end) begin
                                if (st == ST_FCS) begin
                                    if (fcs_lo) st <= ST_FLAG;
                                    fcs_lo <= 1'b1;
                                end else if (mid_load) begin
                                    sh <= held.data; cur_eom <= held.eom;
                                end else begin
                                    st <= ST_FCS; fcs_lo <= 1'b0; eom_flag <= 1'b1;
                                end
                            end
                        end
                    end
                    ST_ABORT: begin
                        if (acnt == ABORT_END) st <= ST_IDLE;
                        else acnt <= acnt + 1'b1;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R4: the run of ones never passes the stuffing limit outside an abort
    assert_run_limit_R4: assert property (@(posedge clk) disable iff (rst)
        (st != ST_ABORT) |-> (ones <= OW'(STUFF_RUN)));

    // R11: request-to-send is high whenever frame content is on the line
    assert_rts_frame_R11: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DATA || st == ST_FCS) |-> rts);

    // R12: the end-of-message latch is set throughout the check field
    assert_eom_fcs_R12: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FCS) |-> eom_flag);

    // R13: after an idle bit time the line rests high
    assert_idle_mark_R13: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && $past(st == ST_IDLE && bit_en)) |-> txd);

endmodule

// File: tb/sim_bitframe_tx.sv
module sim_bitframe_tx;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic tx_enable = 1'b0, cfg_nrzi = 1'b0, cfg_crc_ones = 1'b1, cfg_idle_flags = 1'b0;
    logic abort_req = 1'b0, in_valid = 1'b0, in_eom = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic in_ready, txd, rts, eom_flag;

    int n_tests = 0, n_fail = 0;
    int div = 0;
    logic en_d = 1'b0;

    bitframe_tx u0 (
        .clk(clk), .rst(rst), .bit_en(bit_en), .tx_enable(tx_enable), .cfg_nrzi(cfg_nrzi),
        .cfg_crc_ones(cfg_crc_ones), .cfg_idle_flags(cfg_idle_flags), .abort_req(abort_req),
        .in_valid(in_valid), .in_data(in_data), .in_eom(in_eom), .in_ready(in_ready),
        .txd(txd), .rts(rts), .eom_flag(eom_flag)
    );

    always #10 clk = ~clk;

    always @(negedge clk) begin
        bit_en = (div == 3);
        div = (div + 1) % 4;
    end
    always @(posedge clk) en_d <= bit_en;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // scoreboard of expected frames (data plus check bytes)
    logic [7:0] exp_q[$];
    int exp_len[$];
    string cur_req = "R6";

    // line monitor and deframer
    int  ones_run = 0, flags_seen = 0, aborts_seen = 0, frames_seen = 0;
    bit  in_frame = 0;
    bit  bq[$];
    logic prev_line = 1'b1;

    task automatic deliver();
        int nb;
        logic [7:0] b, e;
        int len;
        nb = bq.size() - 7;
        frames_seen++;
        if (exp_len.size() == 0) begin
            chk(0, {cur_req, " unexpected frame"}, nb, 0);
            return;
        end
        len = exp_len.pop_front();
        chk(nb == len * 8, {cur_req, " frame length bits"}, nb, len * 8);
        for (int j = 0; j < len; j++) begin
            e = exp_q.pop_front();
            b = 8'h00;
            for (int k = 0; k < 8; k++)
                if (j * 8 + k < nb) b[k] = bq[j * 8 + k];
            chk(b == e, {cur_req, " R6 frame byte"}, b, e);
        end
    endtask

    always @(negedge clk) begin
        logic raw;
        if (en_d) begin
            raw = cfg_nrzi ? (txd == prev_line) : txd;
            prev_line = txd;
            if (raw) begin
                ones_run++;
                if (in_frame) bq.push_back(1'b1);
                if (ones_run == 7 && in_frame) begin
                    aborts_seen++; in_frame = 0; bq.delete();
                end
            end else begin
                if (ones_run == 6) begin
                    flags_seen++;
                    if (in_frame && bq.size() >= 7 + 16) deliver();
                    bq.delete();
                    in_frame = 1;
                end else if (ones_run != 5 && in_frame) begin
                    bq.push_back(1'b0);
                end
                ones_run = 0;
            end
        end
    end

    // driver
    logic [7:0] fb[0:15];
    logic rts_mid, eom_mid;

    task automatic put_byte(input logic [7:0] d, input logic e);
        do @(negedge clk); while (!in_ready);
        in_valid = 1'b1; in_data = d; in_eom = e;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_frame(input int n, input bit with_eom);
        logic [15:0] c;
        logic f;
        c = cfg_crc_ones ? 16'hFFFF : 16'h0000;
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 8; k++) begin
                f = c[15] ^ fb[i][k];
                c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
            end
            exp_q.push_back(fb[i]);
        end
        exp_q.push_back(~c[15:8]);
        exp_q.push_back(~c[7:0]);
        exp_len.push_back(n + 2);
        for (int i = 0; i < n; i++) begin
            put_byte(fb[i], with_eom && (i == n - 1));
            if (i == 1) begin rts_mid = rts; eom_mid = eom_flag; end
        end
    endtask

    task automatic wait_done();
        repeat (12) @(negedge clk);
        while (rts) @(negedge clk);
        repeat (120) @(negedge clk);
    endtask

    initial begin
        int f0, a0, fr0, hi;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R14 reset state
        chk(txd == 1'b1, "R14 txd", txd, 1);
        chk(rts == 1'b0, "R14 rts", rts, 0);
        chk(in_ready == 1'b1, "R14 in_ready", in_ready, 1);
        chk(eom_flag == 1'b0, "R14 eom_flag", eom_flag, 0);

        // R2: held byte waits while disabled, then opening flag is automatic
        cur_req = "R2";
        f0 = flags_seen;
        fb[0] = 8'hA5;
        send_frame(1, 1);
        repeat (160) @(negedge clk);
        chk(rts == 1'b0, "R2 no start while disabled", rts, 0);
        chk(in_ready == 1'b0, "R1 holding register full", in_ready, 0);
        tx_enable = 1'b1;
        repeat (12) @(negedge clk);
        chk(rts == 1'b1, "R11 rts raised for frame", rts, 1);
        wait_done();
        chk(flags_seen - f0 == 2, "R2 opening and closing flag", flags_seen - f0, 2);
        chk(eom_flag == 1'b1, "R12 latch set after frame", eom_flag, 1);
        chk(rts == 1'b0, "R11 rts dropped after closing flag", rts, 0);

        // R4 zero insertion with long runs of ones
        cur_req = "R4";
        fb[0] = 8'hFF; fb[1] = 8'hFF; fb[2] = 8'h7E; fb[3] = 8'h3F; fb[4] = 8'hF8;
        send_frame(5, 1);
        chk(rts_mid == 1'b1, "R11 rts high in frame", rts_mid, 1);
        chk(eom_mid == 1'b0, "R12 latch cleared at frame start", eom_mid, 0);
        wait_done();

        // R3 bit order
        cur_req = "R3";
        fb[0] = 8'h01; fb[1] = 8'h80; fb[2] = 8'hC3;
        send_frame(3, 1);
        wait_done();

        // R5 preset to zeros
        cur_req = "R5";
        cfg_crc_ones = 1'b0;
        fb[0] = 8'h12; fb[1] = 8'h34; fb[2] = 8'h56;
        send_frame(3, 1);
        wait_done();
        cfg_crc_ones = 1'b1;

        // R8 back-to-back frames share one flag
        cur_req = "R8";
        f0 = flags_seen; fr0 = frames_seen;
        fb[0] = 8'h11; fb[1] = 8'h22; fb[2] = 8'h33;
        send_frame(3, 1);
        fb[0] = 8'h44; fb[1] = 8'h55;
        send_frame(2, 1);
        wait_done();
        chk(frames_seen - fr0 == 2, "R8 two frames", frames_seen - fr0, 2);
        chk(flags_seen - f0 == 3, "R8 shared flag count", flags_seen - f0, 3);

        // R7 underrun closes the frame
        cur_req = "R7";
        fr0 = frames_seen;
        fb[0] = 8'h9A; fb[1] = 8'hBC;
        send_frame(2, 0);
        wait_done();
        chk(frames_seen - fr0 == 1, "R7 underrun frame closed", frames_seen - fr0, 1);
        chk(eom_flag == 1'b1, "R12 latch set on underrun", eom_flag, 1);

        // R10 NRZI coding and forced-high line afterwards
        cur_req = "R10";
        cfg_nrzi = 1'b1;
        fb[0] = 8'h00; fb[1] = 8'hFF; fb[2] = 8'h55;
        send_frame(3, 1);
        wait_done();
        hi = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (txd) hi++;
        end
        chk(hi == 80, "R10 line high after closing flag", hi, 80);
        cfg_nrzi = 1'b0;
        repeat (20) @(negedge clk);

        // R9 abort in the data field
        cur_req = "R9";
        a0 = aborts_seen; fr0 = frames_seen;
        put_byte(8'h0F, 1'b0);
        put_byte(8'hF0, 1'b0);
        @(negedge clk); abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
        wait_done();
        chk(aborts_seen - a0 == 1, "R9 abort seen on line", aborts_seen - a0, 1);
        chk(frames_seen == fr0, "R9 no frame delivered", frames_seen - fr0, 0);
        chk(in_ready == 1'b1, "R9 held byte dropped", in_ready, 1);
        chk(rts == 1'b0, "R11 rts low after abort", rts, 0);

        // R13 idle flags, then a frame out of idle flags
        cur_req = "R13";
        cfg_idle_flags = 1'b1;
        f0 = flags_seen;
        repeat (200) @(negedge clk);
        chk(flags_seen - f0 >= 3, "R13 flags while idle", flags_seen - f0, 3);
        chk(rts == 1'b0, "R13 rts low while idle flags", rts, 0);
        fb[0] = 8'hE7; fb[1] = 8'h18;
        send_frame(2, 1);
        wait_done();
        cfg_idle_flags = 1'b0;
        repeat (80) @(negedge clk);

        chk(exp_len.size() == 0, "R6 all expected frames delivered", exp_len.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule